// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block pairs two 8-input priority resolvers into one 16-input interrupt controller. The lower eight request lines belong to the master resolver and the upper eight to the slave. A pending slave request is carried into the master through the master's cascade input 2, so the processor sees a single interrupt output. Each request line is either edge-triggered or level-triggered. The choice is held in two byte-wide trigger-mode registers, one per resolver, that are written and read through a plain register port. Some inputs of each resolver are fixed to edge mode.

When the processor acknowledges, the block works out the 8-bit vector and updates the state of both resolvers in the same clock edge. The vector is the owning resolver's 5-bit base followed by the 3-bit number of the winning pin. If the master has nothing pending, the spurious code for master pin 7 is returned. If the master's winner is the cascade input, the slave supplies both the pin and the base. Acknowledging a slave vector accepts the slave pin and master input 2 together.

The acknowledge is a valid/ready exchange. The processor offers `ack_valid_i`, and the block takes it only while `ack_ready_o` is high, which is whenever no vector is being held. The vector then appears on `vec_data_o` with `vec_valid_o` on the next cycle. It stays there unchanged until the processor takes it with `vec_ready_i`. While a vector is held, further acknowledges are refused. The base codes and the per-resolver "initialised" flags arrive on plain configuration pins from the command logic, which lies outside this block.

Top module: `cpic_cascade`

## Requirements
- R1: In edge mode (trigger bit 0), a request bit is set on the clock edge where its line is 1 and was 0 at the previous edge. A line that is already high when its resolver becomes ready sets nothing.
- R2: In level mode (trigger bit 1), a request bit is set on every clock edge where its line is high and its resolver is ready.
- R3: A write with `elc_sel_i`=0 stores `elc_wdata_i & 8'hF8` as the master trigger mode, so master pins 0, 1 and 2 stay edge-triggered. A write with `elc_sel_i`=1 stores `elc_wdata_i & 8'hDE` as the slave trigger mode, so slave pins 0 and 5 stay edge-triggered. `elc_rdata_o` shows the register picked by `elc_sel_i`.
- R4: The slave is evaluated first. When the slave has a pending request and its raised flag is clear, it sets its raised flag and master request bit 2 in the same edge. The master raises one edge later. External line 2 (`irq_i[2]`) has no effect.
- R5: A resolver with a pending request and a clear raised flag sets its raised flag. The flag stays set, blocking further notification, until that resolver has a pin accepted.
- R6: `intr_o` is the registered master raised flag. It is 0 in the cycle after an acknowledge transfer.
- R7: The lowest-numbered pending pin wins (pin 0 has the highest priority). The vector is {base[4:0], pin[2:0]}.
- R8: With no master request pending, the vector is {master base, 3'd7}, and master pin 7 is accepted.
- R9: When the master winner is pin 2, the vector is {slave base, slave winner}, or {slave base, 3'd7} if the slave has nothing pending. The slave pin and master pin 2 are both accepted.
- R10: Accepting a pin clears its request bit only if its line is low in that cycle. The cascade input counts as low. A request bit being set wins over a clear in the same edge.
- R11: While `ready_i[0]` (master) or `ready_i[1]` (slave) is 0, that resolver's request lines set no request bits.
- R12: After reset, `intr_o`=0, `vec_valid_o`=0, `ack_ready_o`=1 and both trigger registers are 0. `ack_ready_o` is the inverse of `vec_valid_o`. A held vector keeps `vec_valid_o` and `vec_data_o` unchanged until `vec_ready_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines; bits 7:0 master, bits 15:8 slave |
| ready_i | input | 2 | Initialised flags; bit 0 master, bit 1 slave |
| base_m_i | input | 5 | Master vector base (vector bits 7:3) |
| base_s_i | input | 5 | Slave vector base (vector bits 7:3) |
| elc_we_i | input | 1 | Trigger-mode register write strobe |
| elc_sel_i | input | 1 | Trigger-mode register select: 0 master, 1 slave |
| elc_wdata_i | input | 8 | Trigger-mode write data, 1 = level |
| elc_rdata_o | output | 8 | Selected trigger-mode register |
| intr_o | output | 1 | Interrupt to the processor |
| ack_valid_i | input | 1 | Acknowledge request |
| ack_ready_o | output | 1 | Acknowledge can be taken |
| vec_valid_o | output | 1 | Vector held for the processor |
| vec_ready_i | input | 1 | Processor takes the vector |
| vec_data_o | output | 8 | Interrupt vector |

## Verification
The case that matters most is an acknowledge that accepts a pin in the same cycle as a new rising edge arrives on that pin's line. The bench provokes it on purpose: it raises the line in the same cycle as `ack_valid_i` for a pin that is already pending. The check is that the request survives and `intr_o` rises again one cycle after it dropped, giving a second vector for the same pin. A cycle model in the bench also compares every output on every cycle while random line toggles and random acknowledges overlap. In that run, slave notification, cascade setting and acceptance of master pin 2 can fall in the same edge, and each such edge is judged against the model.

// File: rtl/cpic_pkg.sv
`timescale 1ns/1ps
package cpic_pkg;

  // Which resolver answers an acknowledge.
  typedef enum logic [1:0] {
    SRC_MASTER = 2'd0,
    SRC_SLAVE  = 2'd1,
    SRC_SPUR   = 2'd2
  } cpic_src_e;

endpackage

// File: rtl/cpic_trigger.sv
`timescale 1ns/1ps
// Per-pin edge/level detection for one resolver.
module cpic_trigger #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready_i,
  input  logic [NPIN-1:0] lines_i,
  input  logic [NPIN-1:0] lvl_i,
  output logic [NPIN-1:0] set_o
);

  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines_i;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    // Edge: high now, low at the previous edge. Level: high now.
    assign set_o[g] = ready_i & lines_i[g] & (~prev_q[g] | lvl_i[g]);
  end

endmodule

// File: rtl/cpic_lvl_regs.sv
`timescale 1ns/1ps
// Trigger-mode registers for both resolvers, with protected pins forced to edge.
module cpic_lvl_regs #(
  parameter int unsigned     NPIN    = 8,
  parameter logic [NPIN-1:0] ALLOW_M = 8'hF8,
  parameter logic [NPIN-1:0] ALLOW_S = 8'hDE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  output logic [NPIN-1:0] lvl_m_o,
  output logic [NPIN-1:0] lvl_s_o
);

  logic [NPIN-1:0] lvl_q [2];

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    localparam logic [NPIN-1:0] ALLOW = (c == 0) ? ALLOW_M : ALLOW_S;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             lvl_q[c] <= '0;
      else if (we_i && (sel_i == (c != 0)))  lvl_q[c] <= wdata_i & ALLOW;
    end
  end

  assign lvl_m_o = lvl_q[0];
  assign lvl_s_o = lvl_q[1];
  assign rdata_o = sel_i ? lvl_q[1] : lvl_q[0];

endmodule

// File: rtl/cpic_resolver.sv
`timescale 1ns/1ps
// One priority resolver: request bits, raised flag, winner selection.
module cpic_resolver #(
  parameter int unsigned PIN_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<PIN_W)-1:0] set_i,
  input  logic [(1<<PIN_W)-1:0] line_i,
  input  logic                  accept_i,
  input  logic [PIN_W-1:0]      accept_pin_i,
  output logic [(1<<PIN_W)-1:0] req_o,
  output logic                  raised_o,
  output logic                  pend_o,
  output logic [PIN_W-1:0]      best_o,
  output logic                  notify_o
);

  localparam int unsigned NPIN = 1 << PIN_W;

  logic [NPIN-1:0] req_q;
  logic [NPIN-1:0] clr;
  logic            raised_q;

  // Lowest-numbered pending pin wins.
  always_comb begin
    best_o = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (req_q[i]) best_o = PIN_W'(i);
    end
  end

  // An accepted pin drops its request only when its line is low.
  always_comb begin
    clr = '0;
    if (accept_i) clr[accept_pin_i] = ~line_i[accept_pin_i];
  end

  assign pend_o   = |req_q;
  assign notify_o = ~raised_q & pend_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      raised_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~clr) | set_i;
      if (accept_i)      raised_q <= 1'b0;
      else if (notify_o) raised_q <= 1'b1;
    end
  end

  assign req_o    = req_q;
  assign raised_o = raised_q;

endmodule

// File: rtl/cpic_ack.sv
`timescale 1ns/1ps
// Acknowledge unit: picks the answering resolver, forms and holds the vector.
module cpic_ack
  import cpic_pkg::*;
#(
  parameter int unsigned PIN_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CASC_PIN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   m_pend_i,
  input  logic [PIN_W-1:0]       m_best_i,
  input  logic                   s_pend_i,
  input  logic [PIN_W-1:0]       s_best_i,
  input  logic [VEC_W-PIN_W-1:0] base_m_i,
  input  logic [VEC_W-PIN_W-1:0] base_s_i,
  input  logic                   ack_valid_i,
  output logic                   ack_ready_o,
  output logic                   vec_valid_o,
  input  logic                   vec_ready_i,
  output logic [VEC_W-1:0]       vec_data_o,
  output logic                   m_acc_o,
  output logic [PIN_W-1:0]       m_pin_o,
  output logic                   s_acc_o,
  output logic [PIN_W-1:0]       s_pin_o
);

  localparam logic [PIN_W-1:0] SPUR = '1;
  localparam logic [PIN_W-1:0] CASC = PIN_W'(CASC_PIN);

  cpic_src_e        src;
  logic             fire;
  logic [VEC_W-1:0] vec;
  logic             vv_q;
  logic [VEC_W-1:0] vd_q;

  assign ack_ready_o = ~vv_q;
  assign fire        = ack_valid_i & ~vv_q;

  always_comb begin
    if (!m_pend_i)             src = SRC_SPUR;
    else if (m_best_i == CASC) src = SRC_SLAVE;
    else                       src = SRC_MASTER;
  end

  always_comb begin
    m_acc_o = fire;
    s_acc_o = 1'b0;
    s_pin_o = s_pend_i ? s_best_i : SPUR;
    unique case (src)
      SRC_SLAVE: begin
        m_pin_o = CASC;
        s_acc_o = fire;
        vec     = {base_s_i, s_pin_o};
      end
      SRC_MASTER: begin
        m_pin_o = m_best_i;
        vec     = {base_m_i, m_best_i};
      end
      default: begin
        m_pin_o = SPUR;
        vec     = {base_m_i, SPUR};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q <= 1'b0;
      vd_q <= '0;
    end else if (fire) begin
      vv_q <= 1'b1;
      vd_q <= vec;
    end else if (vec_ready_i) begin
      vv_q <= 1'b0;
    end
  end

  assign vec_valid_o = vv_q;
  assign vec_data_o  = vd_q;

endmodule

// File: rtl/cpic_cascade.sv
`timescale 1ns/1ps
// Master/slave interrupt controller pair with cascade on master input 2.
module cpic_cascade #(
  parameter int unsigned PIN_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CASC_PIN = 2,
  parameter logic [7:0]  ALLOW_M  = 8'hF8,
  parameter logic [7:0]  ALLOW_S  = 8'hDE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            irq_i,
  input  logic [1:0]             ready_i,
  input  logic [VEC_W-PIN_W-1:0] base_m_i,
  input  logic [VEC_W-PIN_W-1:0] base_s_i,
  input  logic                   elc_we_i,
  input  logic                   elc_sel_i,
  input  logic [7:0]             elc_wdata_i,
  output logic [7:0]             elc_rdata_o,
  output logic                   intr_o,
  input  logic                   ack_valid_i,
  output logic                   ack_ready_o,
  output logic                   vec_valid_o,
  input  logic                   vec_ready_i,
  output logic [VEC_W-1:0]       vec_data_o
);

  localparam int unsigned     NPIN     = 1 << PIN_W;
  localparam logic [NPIN-1:0] CASC_BIT = NPIN'(1) << CASC_PIN;

  logic [NPIN-1:0]  m_lines, s_lines;
  logic [NPIN-1:0]  lvl_m, lvl_s;
  logic [NPIN-1:0]  m_trig, s_trig, m_set;
  logic [NPIN-1:0]  m_req, s_req;
  logic             m_raised, s_raised;
  logic             m_pend, s_pend, m_notify, s_notify;
  logic [PIN_W-1:0] m_best, s_best, m_pin, s_pin;
  logic             m_acc, s_acc;

  // Master input 2 belongs to the cascade; the external line there is dropped.
  assign m_lines = irq_i[NPIN-1:0] & ~CASC_BIT;
  assign s_lines = irq_i[2*NPIN-1:NPIN];

  cpic_lvl_regs #(.NPIN(NPIN), .ALLOW_M(ALLOW_M), .ALLOW_S(ALLOW_S)) u_lvl (
    .clk(clk), .rst_n(rst_n), .we_i(elc_we_i), .sel_i(elc_sel_i),
    .wdata_i(elc_wdata_i), .rdata_o(elc_rdata_o), .lvl_m_o(lvl_m), .lvl_s_o(lvl_s)
  );

  cpic_trigger #(.NPIN(NPIN)) u_trig_m (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i[0]), .lines_i(m_lines),
    .lvl_i(lvl_m), .set_o(m_trig)
  );

  cpic_trigger #(.NPIN(NPIN)) u_trig_s (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i[1]), .lines_i(s_lines),
    .lvl_i(lvl_s), .set_o(s_trig)
  );

  // Slave notification pulses master input 2 in the same edge.
  assign m_set = m_trig | (s_notify ? CASC_BIT : '0);

  cpic_resolver #(.PIN_W(PIN_W)) u_res_s (
    .clk(clk), .rst_n(rst_n), .set_i(s_trig), .line_i(s_lines),
    .accept_i(s_acc), .accept_pin_i(s_pin), .req_o(s_req), .raised_o(s_raised),
    .pend_o(s_pend), .best_o(s_best), .notify_o(s_notify)
  );

  cpic_resolver #(.PIN_W(PIN_W)) u_res_m (
    .clk(clk), .rst_n(rst_n), .set_i(m_set), .line_i(m_lines),
    .accept_i(m_acc), .accept_pin_i(m_pin), .req_o(m_req), .raised_o(m_raised),
    .pend_o(m_pend), .best_o(m_best), .notify_o(m_notify)
  );

  cpic_ack #(.PIN_W(PIN_W), .VEC_W(VEC_W), .CASC_PIN(CASC_PIN)) u_ack (
    .clk(clk), .rst_n(rst_n), .m_pend_i(m_pend), .m_best_i(m_best),
    .s_pend_i(s_pend), .s_best_i(s_best), .base_m_i(base_m_i), .base_s_i(base_s_i),
    .ack_valid_i(ack_valid_i), .ack_ready_o(ack_ready_o), .vec_valid_o(vec_valid_o),
    .vec_ready_i(vec_ready_i), .vec_data_o(vec_data_o), .m_acc_o(m_acc),
    .m_pin_o(m_pin), .s_acc_o(s_acc), .s_pin_o(s_pin)
  );

  assign intr_o = m_raised;

endmodule

// File: rtl/cpic_checker.sv
`timescale 1ns/1ps
// Property checker bound to the cascaded controller.
module cpic_checker #(
  parameter int unsigned PIN_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CASC_PIN = 2,
  parameter logic [7:0]  ALLOW_M  = 8'hF8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             ready_i,
  input logic [VEC_W-PIN_W-1:0] base_m_i,
  input logic                   elc_we_i,
  input logic                   elc_sel_i,
  input logic [7:0]             elc_wdata_i,
  input logic                   intr_o,
  input logic                   ack_valid_i,
  input logic                   ack_ready_o,
  input logic                   vec_valid_o,
  input logic                   vec_ready_i,
  input logic [VEC_W-1:0]       vec_data_o,
  input logic [(1<<PIN_W)-1:0]  m_req,
  input logic                   s_raised,
  input logic [(1<<PIN_W)-1:0]  lvl_m
);

  localparam int unsigned     NPIN     = 1 << PIN_W;
  localparam logic [NPIN-1:0] CASC_BIT = NPIN'(1) << CASC_PIN;

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_data_o));

  a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> !ack_ready_o);

  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_i && ack_ready_o |=> !intr_o);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o && !(ack_valid_i && ack_ready_o) |=> intr_o);

  a_r4_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_raised) |-> m_req[CASC_PIN]);

  a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_i && ack_ready_o && (m_req == '0)
    |=> vec_data_o == {$past(base_m_i), PIN_W'(NPIN - 1)});

  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i[0] |=> ((m_req & ~$past(m_req) & ~CASC_BIT) == '0));

  a_r3_master_mask: assert property (@(posedge clk) disable iff (!rst_n)
    elc_we_i && !elc_sel_i |=> lvl_m == ($past(elc_wdata_i) & ALLOW_M));

endmodule

bind cpic_cascade cpic_checker #(
  .PIN_W(PIN_W), .VEC_W(VEC_W), .CASC_PIN(CASC_PIN), .ALLOW_M(ALLOW_M)
) u_cpic_chk (
  .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .base_m_i(base_m_i),
  .elc_we_i(elc_we_i), .elc_sel_i(elc_sel_i), .elc_wdata_i(elc_wdata_i),
  .intr_o(intr_o), .ack_valid_i(ack_valid_i), .ack_ready_o(ack_ready_o),
  .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i), .vec_data_o(vec_data_o),
  .m_req(m_req), .s_raised(s_raised), .lvl_m(lvl_m)
);

// File: tb/test_cpic_cascade.sv
`timescale 1ns/1ps
module test_cpic_cascade;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic [1:0]  ready = 2'b11;
  logic [4:0]  bm = 5'h01;
  logic [4:0]  bs = 5'h0E;
  logic        elc_we = 1'b0, elc_sel = 1'b0;
  logic [7:0]  elc_wd = '0;
  logic [7:0]  elc_rd;
  logic        intr, ack_valid = 1'b0, ack_ready, vec_valid, vec_ready = 1'b0;
  logic [7:0]  vec_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  always #5 clk = ~clk;

  cpic_cascade i_cpic_cascade (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .ready_i(ready), .base_m_i(bm),
    .base_s_i(bs), .elc_we_i(elc_we), .elc_sel_i(elc_sel), .elc_wdata_i(elc_wd),
    .elc_rdata_o(elc_rd), .intr_o(intr), .ack_valid_i(ack_valid),
    .ack_ready_o(ack_ready), .vec_valid_o(vec_valid), .vec_ready_i(vec_ready),
    .vec_data_o(vec_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] low8(input logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  // ---- cycle model built from the requirements ----
  logic [7:0]  md_mreq, md_sreq, md_elm, md_els, md_vd;
  logic [15:0] md_prev;
  logic        md_mr, md_sr, md_vv;

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] ml, sl, mset, sset, mclr, sclr, vec;
    logic       sn, mn, fire, macc, sacc;
    logic [2:0] mp, sp;
    if (!rst_n) begin
      md_mreq = '0; md_sreq = '0; md_elm = '0; md_els = '0; md_vd = '0;
      md_prev = '0; md_mr = 0; md_sr = 0; md_vv = 0;
    end else begin
      ml   = irq[7:0] & 8'hFB;
      sl   = irq[15:8];
      mset = ready[0] ? (ml & (~md_prev[7:0] | md_elm)) : 8'h00;
      sset = ready[1] ? (sl & (~md_prev[15:8] | md_els)) : 8'h00;
      sn   = !md_sr && (md_sreq != 0);
      mn   = !md_mr && (md_mreq != 0);
      if (sn) mset[2] = 1'b1;
      fire = ack_valid && !md_vv;
      macc = 0; sacc = 0; mp = 0; sp = 0; vec = '0;
      if (fire) begin
        macc = 1;
        if (md_mreq == 0) begin
          mp = 3'd7; vec = {bm, 3'd7};
        end else if (low8(md_mreq) == 3'd2) begin
          mp = 3'd2; sacc = 1;
          sp = (md_sreq != 0) ? low8(md_sreq) : 3'd7;
          vec = {bs, sp};
        end else begin
          mp = low8(md_mreq); vec = {bm, mp};
        end
      end
      mclr = macc ? ((8'd1 << mp) & ~ml) : 8'h00;
      sclr = sacc ? ((8'd1 << sp) & ~sl) : 8'h00;
      md_mreq = (md_mreq & ~mclr) | mset;
      md_sreq = (md_sreq & ~sclr) | sset;
      md_mr = macc ? 1'b0 : (mn ? 1'b1 : md_mr);
      md_sr = sacc ? 1'b0 : (sn ? 1'b1 : md_sr);
      if (elc_we) begin
        if (elc_sel) md_els = elc_wd & 8'hDE;
        else         md_elm = elc_wd & 8'hF8;
      end
      if (fire) begin md_vv = 1; md_vd = vec; end
      else if (md_vv && vec_ready) md_vv = 0;
      md_prev = irq;
    end
  end

  // Every-cycle comparison, after inputs and combinational outputs settle.
  always begin
    @(negedge clk);
    #2;
    if (rst_n && cmp_on) begin
      chk("R6 intr vs model", intr, md_mr);
      chk("R12 ack_ready vs model", ack_ready, !md_vv);
      chk("R12 vec_valid vs model", vec_valid, md_vv);
      if (md_vv) chk("R7 vector vs model", vec_data, md_vd);
      chk("R3 elc readback vs model", elc_rd, elc_sel ? md_els : md_elm);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    ack_valid = 1'b1;
    tick();
    ack_valid = 1'b0;
    chk({tag, " vec_valid"}, vec_valid, 1'b1);
    chk(tag, vec_data, exp);
    chk("R6 intr low after ack", intr, 1'b0);
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
  endtask

  task automatic pulse(input int line);
    irq[line] = 1'b1;
    tick();
    irq[line] = 1'b0;
  endtask

  task automatic elc_write(input logic sel, input logic [7:0] d);
    elc_we = 1'b1; elc_sel = sel; elc_wd = d;
    tick();
    elc_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 reset intr", intr, 1'b0);
    chk("R12 reset vec_valid", vec_valid, 1'b0);
    chk("R12 reset ack_ready", ack_ready, 1'b1);
    chk("R12 reset elc", elc_rd, 8'h00);
    cmp_on = 1;

    // R3 protected trigger bits
    elc_write(1'b0, 8'hFF); #1;
    chk("R3 master mask F8", elc_rd, 8'hF8);
    elc_write(1'b1, 8'hFF); #1;
    chk("R3 slave mask DE", elc_rd, 8'hDE);
    elc_write(1'b0, 8'h00);
    elc_write(1'b1, 8'h00);
    elc_sel = 1'b0;

    // R1 / R7 single master edge
    pulse(5); tick();
    chk("R1 edge raises intr", intr, 1'b1);
    do_ack("R7 vector pin5", 8'h0D);
    tick(2);
    chk("R1 no further intr", intr, 1'b0);

    // R7 priority, R5 re-raise after accept
    irq[3] = 1'b1; irq[6] = 1'b1; tick();
    irq[3] = 1'b0; irq[6] = 1'b0; tick();
    chk("R5 intr pin3+6", intr, 1'b1);
    do_ack("R7 lowest pin wins", 8'h0B);
    chk("R5 re-raised for pin6", intr, 1'b1);
    do_ack("R7 second pin", 8'h0E);

    // R8 spurious
    tick();
    do_ack("R8 spurious vector", 8'h0F);

    // R4 / R9 slave through cascade
    pulse(11); tick();
    chk("R4 master not yet raised", intr, 1'b0);
    tick();
    chk("R4 cascade raises intr", intr, 1'b1);
    do_ack("R9 slave vector", 8'h73);
    tick(2);
    chk("R9 cascade input accepted", intr, 1'b0);
    pulse(2); tick(3);
    chk("R4 external line 2 ignored", intr, 1'b0);

    // R10 line held high at acceptance keeps the request
    irq[1] = 1'b1; tick(2);
    chk("R10 intr pin1", intr, 1'b1);
    do_ack("R10 vector pin1", 8'h09);
    chk("R10 request kept while high", intr, 1'b1);
    irq[1] = 1'b0;
    do_ack("R10 vector pin1 again", 8'h09);
    tick(2);
    chk("R10 cleared once low", intr, 1'b0);

    // Concurrency: rising edge in the same cycle as acceptance of that pin
    pulse(5); tick();
    chk("R10 intr before overlap", intr, 1'b1);
    ack_valid = 1'b1; irq[5] = 1'b1;
    tick();
    ack_valid = 1'b0; irq[5] = 1'b0;
    chk("R10 overlap vector", vec_data, 8'h0D);
    vec_ready = 1'b1; tick(); vec_ready = 1'b0;
    chk("R10 set wins over clear", intr, 1'b1);
    do_ack("R10 overlap second vector", 8'h0D);
    tick(2);

    // R11 not ready, R2 level vs R1 edge across ready
    ready = 2'b10;
    pulse(4); ready = 2'b11; tick(2);
    chk("R11 line ignored when not ready", intr, 1'b0);
    elc_write(1'b0, 8'h10);
    ready = 2'b10; irq[4] = 1'b1; tick(2);
    ready = 2'b11; tick(2);
    chk("R2 level sets after ready", intr, 1'b1);
    irq[4] = 1'b0; tick();
    do_ack("R2 level vector", 8'h0C);
    tick(2);
    chk("R2 cleared when low", intr, 1'b0);
    elc_write(1'b0, 8'h00);
    ready = 2'b10; irq[6] = 1'b1; tick(2);
    ready = 2'b11; tick(3);
    chk("R1 held edge line missed", intr, 1'b0);
    irq[6] = 1'b0; tick();

    // R12 back-pressure
    pulse(0); tick();
    ack_valid = 1'b1; tick(); ack_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R12 vector held valid", vec_valid, 1'b1);
      chk("R12 vector held data", vec_data, 8'h08);
      chk("R12 ack refused while held", ack_ready, 1'b0);
    end
    ack_valid = 1'b0;
    vec_ready = 1'b1; tick(); vec_ready = 1'b0;
    chk("R12 released", vec_valid, 1'b0);
    tick(3);

    // Constrained random mix, judged by the model
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 16; b++) if ($urandom_range(15) == 0) irq[b] = ~irq[b];
      ready[0] = ($urandom_range(31) != 0);
      ready[1] = ($urandom_range(31) != 0);
      ack_valid = ($urandom_range(3) == 0);
      vec_ready = $urandom_range(1);
      elc_sel   = $urandom_range(1);
      elc_we    = ($urandom_range(63) == 0);
      elc_wd    = 8'($urandom);
      tick();
    end
    ack_valid = 1'b0; elc_we = 1'b0; irq = '0;
    tick(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule